// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block is the digital controller of an 18-bit charge-redistribution successive approximation converter. While idle the converter tracks its input. A low-to-high transition on the convert input ends tracking and starts a conversion. The sequencer then resolves the code one bit at a time, most significant bit first, on the internal clock. For each trial it drives one more weighted switch of the capacitor DAC and reads a one-bit comparator decision. The serial clock takes no part in this.

Each trial lasts a fixed number of internal clock cycles, set by a parameter. The comparator is read only in the last cycle of a trial. Once a conversion has begun it runs to the end, whatever the convert input does. At the end the sequencer returns the switch word to the tracking state. In the same cycle it loads the result register with a two's complement code, drops the busy flag and pulses done for one cycle. There is no pipeline delay.

The trial register works in offset binary. The published code is that word with its top bit inverted. A comparator that always says "above" or always says "below" therefore gives the two saturation codes on its own, with no extra logic.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, busy, done, the result and the switch word are all zero.
- R2: A conversion starts only when the convert input is sampled high on a clock edge after being sampled low on the previous edge. Busy is high from the cycle after that edge. Holding the input high starts no further conversion.
- R3: The trials run from bit 17 down to bit 0. During trial k the switch word holds the bits already resolved in positions above 17-k, a one in position 17-k, and zeros below it.
- R4: The comparator is sampled in the last cycle of each trial. A high value keeps the trial bit and a low value clears it.
- R5: Busy stays high for exactly 18 × TRIAL_CYC cycles. The default TRIAL_CYC of 3 gives 54 cycles, or 432 ns with an 8 ns clock.
- R6: Rising edges on the convert input while busy is high are ignored. They neither shorten the conversion nor start another one after it.
- R7: The result is two's complement: the offset-binary trial word with bit 17 inverted. Midscale gives 0x00000, one step above midscale gives 0x00001, and one step below gives 0x3FFFF.
- R8: A comparator that is high for every trial gives 0x1FFFF (overrange). One that is low for every trial gives 0x20000 (underrange).
- R9: Done is a single-cycle pulse in the first cycle after busy falls, and the new result is valid in that same cycle. The result then holds until the next done.
- R10: While no conversion is running, the switch word is zero (tracking).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_i | input | 1 | Convert request; a rising edge starts a conversion |
| comp_i | input | 1 | Comparator decision; high means the input is at or above the trial level |
| dac_word_o | output | 18 | Capacitor DAC switch word; one bit per weighted element |
| busy_o | output | 1 | High while a conversion is in progress |
| done_o | output | 1 | One-cycle pulse when a new result is loaded |
| result_o | output | 18 | Last conversion result, two's complement |

## Verification
The assertions assume that the comparator decision settles within the cycle in which a trial word is presented. They also assume that the convert input is synchronous to the internal clock, so that one sampled low-to-high step counts as one edge. The bench meets both conditions. It computes the comparator bit combinationally from the switch word and a held input value, and it changes the convert input only on falling clock edges. To cover the saturation cases, the bench forces the comparator high or low instead of holding a value.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    // Converter phase: tracking the input, or resolving bits
    typedef enum logic {
        PH_TRACK = 1'b0,
        PH_RESOLVE = 1'b1
    } phase_e;

endpackage

// File: rtl/sar_edge_det.sv
module sar_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o
);

    typedef struct packed {
        logic prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl_i;
        rise_o    = lvl_i & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sar_trial_ctrl.sv
module sar_trial_ctrl
    import sar_seq_pkg::*;
#(
    parameter int NBITS     = 18,
    parameter int TRIAL_CYC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             comp_i,
    output logic [NBITS-1:0] dac_o,
    output logic             busy_o,
    output logic             last_o,
    output logic [NBITS-1:0] resolved_o
);

    localparam int IDX_W  = (NBITS > 1) ? $clog2(NBITS) : 1;
    localparam int PACE_W = (TRIAL_CYC > 1) ? $clog2(TRIAL_CYC) : 1;
    localparam logic [IDX_W-1:0]  TOP_IDX  = IDX_W'(NBITS - 1);
    localparam logic [PACE_W-1:0] PACE_END = PACE_W'(TRIAL_CYC - 1);
    localparam logic [NBITS-1:0]  MSB_ONE  = {1'b1, {(NBITS-1){1'b0}}};

    typedef struct packed {
        phase_e             phase;
        logic [NBITS-1:0]   word;
        logic [IDX_W-1:0]   idx;
        logic [PACE_W-1:0]  pace;
    } trial_state_t;

    trial_state_t st_d, st_q;
    logic [NBITS-1:0] decided;
    logic             trial_end;

    always_comb begin
        st_d      = st_q;
        last_o    = 1'b0;
        trial_end = (st_q.pace == PACE_END);
        decided   = st_q.word;
        if (!comp_i) begin
            decided[st_q.idx] = 1'b0;
        end

        unique case (st_q.phase)
            PH_TRACK: begin
                if (start_i) begin
                    st_d.phase = PH_RESOLVE;
                    st_d.word  = MSB_ONE;
                    st_d.idx   = TOP_IDX;
                    st_d.pace  = '0;
                end
            end
            PH_RESOLVE: begin
                if (!trial_end) begin
                    st_d.pace = st_q.pace + 1'b1;
                end else begin
                    st_d.pace = '0;
                    if (st_q.idx == '0) begin
                        last_o     = 1'b1;
                        st_d.phase = PH_TRACK;
                        st_d.word  = '0;
                    end else begin
                        st_d.idx            = st_q.idx - 1'b1;
                        st_d.word           = decided;
                        st_d.word[st_d.idx] = 1'b1;
                    end
                end
            end
            default: st_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dac_o      = st_q.word;
    assign busy_o     = (st_q.phase == PH_RESOLVE);
    assign resolved_o = decided;

endmodule

// File: rtl/sar_code_fmt.sv
module sar_code_fmt #(
    parameter int NBITS = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [NBITS-1:0] offset_i,
    output logic [NBITS-1:0] result_o,
    output logic             done_o
);

    typedef struct packed {
        logic [NBITS-1:0] result;
        logic             done;
    } fmt_state_t;

    fmt_state_t st_d, st_q;
    logic [NBITS-1:0] twos;

    // Offset binary to two's complement: invert the sign position only
    generate
        if (NBITS > 1) begin : g_wide
            assign twos = {~offset_i[NBITS-1], offset_i[NBITS-2:0]};
        end else begin : g_single
            assign twos = ~offset_i;
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.done = load_i;
        if (load_i) begin
            st_d.result = twos;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.result;
    assign done_o   = st_q.done;

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
    parameter int NBITS     = 18,
    parameter int TRIAL_CYC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_i,
    input  logic             comp_i,
    output logic [NBITS-1:0] dac_word_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [NBITS-1:0] result_o
);

    logic             conv_rise;
    logic             start;
    logic             last_trial;
    logic [NBITS-1:0] resolved;

    sar_edge_det i_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (conv_i),
        .rise_o (conv_rise)
    );

    // A rising edge only counts while tracking; the controller ignores it otherwise
    assign start = conv_rise & ~busy_o;

    sar_trial_ctrl #(
        .NBITS     (NBITS),
        .TRIAL_CYC (TRIAL_CYC)
    ) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .comp_i     (comp_i),
        .dac_o      (dac_word_o),
        .busy_o     (busy_o),
        .last_o     (last_trial),
        .resolved_o (resolved)
    );

    sar_code_fmt #(
        .NBITS (NBITS)
    ) i_fmt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (last_trial),
        .offset_i (resolved),
        .result_o (result_o),
        .done_o   (done_o)
    );

endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
    parameter int NBITS     = 18,
    parameter int TRIAL_CYC = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             conv_i,
    input logic [NBITS-1:0] dac_word_o,
    input logic             busy_o,
    input logic             done_o,
    input logic [NBITS-1:0] result_o
);

    localparam int TOTAL = NBITS * TRIAL_CYC;
    localparam int LEN_W = $clog2(TOTAL + 1) + 1;

    logic [LEN_W-1:0] busy_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_len_q <= '0;
        end else if (busy_o) begin
            busy_len_q <= busy_len_q + 1'b1;
        end else begin
            busy_len_q <= '0;
        end
    end

    // R2: busy only rises after the convert input was seen high
    a_r2_start_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(conv_i));

    // R5, R6: every conversion lasts the full trial budget
    a_r5_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (busy_len_q == LEN_W'(TOTAL)));

    // R9: done follows the end of busy and lasts one cycle
    a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    // R10: switches idle while tracking
    a_r10_idle_word: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (dac_word_o == '0));

    // R3: a trial bit is always present while resolving
    a_r3_trial_present: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (dac_word_o != '0));

endmodule

bind sar_conv_seq sar_conv_seq_chk #(
    .NBITS     (NBITS),
    .TRIAL_CYC (TRIAL_CYC)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_i     (conv_i),
    .dac_word_o (dac_word_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .result_o   (result_o)
);

// File: tb/test_sar_conv_seq.sv
module test_sar_conv_seq;

    localparam int NB  = 18;
    localparam int TC  = 3;
    localparam int TOT = NB * TC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          conv = 1'b0;
    logic          comp;
    logic [NB-1:0] dac;
    logic [NB-1:0] res;
    logic          busy;
    logic          done;
    logic [NB-1:0] x_held = '0;
    logic          force_hi = 1'b0;
    logic          force_lo = 1'b0;
    int            n_chk = 0;
    int            n_fail = 0;

    always #4 clk = ~clk;

    // Behavioural comparator: held input versus present DAC level
    always_comb begin
        if (force_hi)      comp = 1'b1;
        else if (force_lo) comp = 1'b0;
        else               comp = (x_held >= dac);
    end

    sar_conv_seq #(.NBITS(NB), .TRIAL_CYC(TC)) i_sar_conv_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_i     (conv),
        .comp_i     (comp),
        .dac_word_o (dac),
        .busy_o     (busy),
        .done_o     (done),
        .result_o   (res)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Runs one conversion; x is the offset-binary value the comparator tracks
    task automatic convert(input logic [NB-1:0] x, input logic [NB-1:0] exp_res, input string tag);
        logic [NB-1:0] hi_mask;
        logic [NB-1:0] exp_dac;
        x_held = x;
        @(negedge clk);
        conv = 1'b1;
        for (int i = 1; i <= TOT; i++) begin
            @(negedge clk);
            if (i == 1) check(busy == 1'b1, "R2 busy after edge", 32'(busy), 32'd1);
            if ((i - 1) % TC == 0) begin
                int k;
                k = (i - 1) / TC;
                hi_mask = ~((NB'(1) << (NB - k)) - NB'(1));
                exp_dac = (x & hi_mask) | (NB'(1) << (NB - 1 - k));
                check(dac == exp_dac, "R3 R4 trial word", 32'(dac), 32'(exp_dac));
            end
            if (i == TOT) check(busy && !done, "R5 busy at last trial", {busy, done}, 32'b10);
        end
        @(negedge clk);
        check(!busy && done, "R9 done as busy falls", {busy, done}, 32'b01);
        check(res == exp_res, {"R7 R8 result ", tag}, 32'(res), 32'(exp_res));
        check(dac == '0, "R10 idle word", 32'(dac), 32'd0);
        conv = 1'b0;
        repeat (5) @(negedge clk);
        check(!done && res == exp_res, "R9 result held", 32'(res), 32'(exp_res));
    endtask

    task automatic test_reset;
        check(!busy && !done && res == '0 && dac == '0, "R1 reset state",
              {busy, done, 30'(res)}, 32'd0);
    endtask

    task automatic test_codes;
        convert(18'h20000, 18'h00000, "midscale");
        convert(18'h20001, 18'h00001, "plus one");
        convert(18'h1FFFF, 18'h3FFFF, "minus one");
        convert(18'h2A5C3, 18'h0A5C3, "pattern a");
        convert(18'h05A3C, 18'h25A3C, "pattern b");
    endtask

    task automatic test_saturation;
        force_hi = 1'b1;
        convert(18'h3FFFF, 18'h1FFFF, "overrange");
        force_hi = 1'b0;
        force_lo = 1'b1;
        convert(18'h00000, 18'h20000, "underrange");
        force_lo = 1'b0;
    endtask

    task automatic test_retrigger;
        x_held = 18'h31234;
        @(negedge clk);
        conv = 1'b1;
        for (int i = 1; i <= TOT; i++) begin
            @(negedge clk);
            if (i == 10 || i == 30) conv = 1'b0;
            if (i == 20 || i == 40) conv = 1'b1;
            if (i == TOT) check(busy && !done, "R6 not cut short", {busy, done}, 32'b10);
        end
        @(negedge clk);
        check(done && res == 18'h11234, "R6 result after retrigger", 32'(res), 32'h11234);
        for (int j = 0; j < 10; j++) begin
            @(negedge clk);
            check(!busy, "R6 no extra conversion", 32'(busy), 32'd0);
        end
        conv = 1'b0;
        @(negedge clk);
    endtask

    task automatic test_hold_high;
        x_held = 18'h00FF0;
        @(negedge clk);
        conv = 1'b1;
        repeat (TOT + 1) @(negedge clk);
        check(done, "R2 hold high completes", 32'(done), 32'd1);
        for (int j = 0; j < 2 * TOT; j++) begin
            @(negedge clk);
            if (busy) check(1'b0, "R2 held input restarted", 32'(busy), 32'd0);
        end
        check(!busy && res == 18'h20FF0, "R2 no restart while held", 32'(res), 32'h20FF0);
        conv = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset;
        rst_n = 1'b1;
        @(negedge clk);
        test_reset;
        test_codes;
        test_saturation;
        test_retrigger;
        test_hold_high;
        finish_run;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run;
    end

endmodule